// File: doc/BRIEF.md
# Iterative XTEA Block Encryptor

This block enciphers one 64-bit block with the extended tiny encryption algorithm under a 128-bit key. The block is presented as two 32-bit halves and the key as four 32-bit words. A single-cycle start pulse loads them, and the core then runs its Feistel loop one full cycle per clock. A full cycle updates the first half, then steps the running sum, then updates the second half. There are no substitution tables and no precomputed key schedule. The key word used by each half-update comes from two bits of the running sum.

The design targets small, low-power sensor-node controllers, so area is kept low: one round's worth of adders, a 5-bit counter and the working registers. The result appears on the output halves together with a one-cycle done pulse. It stays there until the next accepted start. A start that arrives while a block is in progress is dropped.

Top module: `xtea_block_enc`

## Requirements
- R1: The ciphertext equals 32 cycles of the XTEA loop applied to the input halves. The running sum starts at zero and grows by 0x9E3779B9 (mod 2^32) once per cycle.
- R2: The first-half update uses key word number sum[1:0], taken from the sum before that cycle's increment. Key word n sits at key_i[32n+31:32n].
- R3: The second-half update happens after the increment and uses key word number sum[12:11] of the incremented sum.
- R4: Each half-update adds its term to its half modulo 2^32. The term is (((o<<4) XOR (o>>5)) + o) XOR (sum + key word), where o is the other half.
- R5: A start sampled at clock edge E raises done_o for exactly one cycle, beginning right after edge E+31, which is 32 cycles after the start cycle.
- R6: busy_o is high from the edge that samples the start up to the edge that raises done_o. It is low while done_o is high.
- R7: A start while busy_o is high is ignored. The data and key presented with it do not change the result or the timing of the block in flight.
- R8: After done_o, the output halves hold their value until the next accepted start.
- R9: After reset, busy_o and done_o are low and both output halves are zero.
- R10: An all-zero key with all-zero data gives the same result as the loop of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads the block and key when idle |
| half0_i | input | 32 | First plaintext half |
| half1_i | input | 32 | Second plaintext half |
| key_i | input | 128 | Key, word n at bits [32n+31:32n] |
| half0_o | output | 32 | First ciphertext half |
| half1_o | output | 32 | Second ciphertext half |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| busy_o | output | 1 | High while a block is being enciphered |

## Verification
The hardest case to reach from the ports is a start that lands while a block is in flight. Such a start comes with different data and key, and any leak of it shows up only in the final ciphertext. The bench fires such starts at chosen points inside a running block: one cycle after the start, in the middle, and on the last busy cycle. It then compares the result and the latency against a bench model run on the original operands. Random blocks drawn from a fixed seed, along with all-zero and all-ones operands, exercise every key-word selection path of R2 and R3.

// File: rtl/xtea_enc_pkg.sv
package xtea_enc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned KEY_N   = 4;
  localparam int unsigned SEL_W   = $clog2(KEY_N);
  localparam int unsigned HI_SEL_LSB = 11;
  localparam logic [WORD_W-1:0] DELTA = 32'h9E37_79B9;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  ksel_t;

  // mixing term added to one half, built from the other half
  function automatic word_t mix_term(word_t other, word_t sum, word_t kw);
    word_t spread;
    spread = ((other << 4) ^ (other >> 5)) + other;
    return spread ^ (sum + kw);
  endfunction

  // key index for the first half-update (sum before increment)
  function automatic ksel_t sel_first(word_t sum);
    return sum[SEL_W-1:0];
  endfunction

  // key index for the second half-update (sum after increment)
  function automatic ksel_t sel_second(word_t sum);
    return sum[HI_SEL_LSB +: SEL_W];
  endfunction
endpackage

// File: rtl/xtea_cycle.sv
module xtea_cycle
  import xtea_enc_pkg::*;
(
  input  word_t                    v0_i,
  input  word_t                    v1_i,
  input  word_t                    sum_i,
  input  logic [KEY_N*WORD_W-1:0]  key_i,
  output word_t                    v0_o,
  output word_t                    v1_o,
  output word_t                    sum_o
);
  word_t kw [KEY_N];
  ksel_t sel_a;
  ksel_t sel_b;
  word_t sum_next;
  word_t v0_next;

  for (genvar g = 0; g < KEY_N; g++) begin : g_kw
    assign kw[g] = key_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    sel_a    = sel_first(sum_i);
    v0_next  = v0_i + mix_term(v1_i, sum_i, kw[sel_a]);
    sum_next = sum_i + DELTA;
    sel_b    = sel_second(sum_next);
    v0_o     = v0_next;
    sum_o    = sum_next;
    v1_o     = v1_i + mix_term(v0_next, sum_next, kw[sel_b]);
  end
endmodule

// File: rtl/xtea_seq.sv
module xtea_seq #(
  parameter int unsigned ROUNDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_step;

  assign accept_o  = start_i && !busy_o;
  assign last_step = busy_o && (cnt_q == LAST);
  assign step_o    = accept_o || busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= CNT_W'(1);
      busy_o <= (ROUNDS > 1);
      done_o <= (ROUNDS == 1);
    end else if (busy_o) begin
      cnt_q  <= cnt_q + 1'b1;
      busy_o <= !last_step;
      done_o <= last_step;
    end else begin
      done_o <= 1'b0;
    end
  end

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done_o);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_step) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/xtea_block_enc.sv
module xtea_block_enc
  import xtea_enc_pkg::*;
#(
  parameter int unsigned ROUNDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   half0_i,
  input  logic [31:0]   half1_i,
  input  logic [127:0]  key_i,
  output logic [31:0]   half0_o,
  output logic [31:0]   half1_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int unsigned KEY_W = KEY_N * WORD_W;

  logic             accept;
  logic             step;
  word_t            v0_q, v1_q, sum_q;
  logic [KEY_W-1:0] key_q;
  word_t            op_v0, op_v1, op_sum;
  logic [KEY_W-1:0] op_key;
  word_t            nx_v0, nx_v1, nx_sum;

  xtea_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  // first cycle runs on the edge that accepts the start
  always_comb begin
    op_v0  = accept ? half0_i : v0_q;
    op_v1  = accept ? half1_i : v1_q;
    op_sum = accept ? '0      : sum_q;
    op_key = accept ? key_i   : key_q;
  end

  xtea_cycle u_cycle (
    .v0_i  (op_v0),
    .v1_i  (op_v1),
    .sum_i (op_sum),
    .key_i (op_key),
    .v0_o  (nx_v0),
    .v1_o  (nx_v1),
    .sum_o (nx_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q  <= '0;
      v1_q  <= '0;
      sum_q <= '0;
      key_q <= '0;
    end else if (step) begin
      v0_q  <= nx_v0;
      v1_q  <= nx_v1;
      sum_q <= nx_sum;
      if (accept) key_q <= key_i;
    end
  end

  assign half0_o = v0_q;
  assign half1_o = v1_q;

  // R1
  sum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (sum_q == $past(sum_q) + DELTA));
  // R7
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (key_q == $past(key_q)));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(half0_o) && $stable(half1_o)));
  // R1
  first_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sum_q == DELTA));
endmodule

// File: tb/xtea_block_enc_tb.sv
module xtea_block_enc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  half0_i = '0, half1_i = '0;
  logic [127:0] key_i = '0;
  logic [31:0]  half0_o, half1_o;
  logic         done_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xtea_block_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .half0_i(half0_i), .half1_i(half1_i), .key_i(key_i),
    .half0_o(half0_o), .half1_o(half1_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  // bench model: reference loop written from R1..R4
  function automatic logic [63:0] ref_enc(logic [31:0] a, logic [31:0] b, logic [127:0] k);
    logic [31:0] s = 32'd0;
    logic [31:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = k[32*i +: 32];
    for (int r = 0; r < 32; r++) begin
      a = a + ((((b << 4) ^ (b >> 5)) + b) ^ (s + w[s & 32'd3]));
      s = s + 32'h9E3779B9;
      b = b + ((((a << 4) ^ (a >> 5)) + a) ^ (s + w[(s >> 11) & 32'd3]));
    end
    return {a, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one block; poke_at>0 fires a foreign start that many cycles in
  task automatic run_block(input logic [31:0] a, input logic [31:0] b,
                           input logic [127:0] k, input int poke_at);
    logic [63:0] exp;
    int cyc;
    bit busy_ok;
    exp = ref_enc(a, b, k);
    @(negedge clk);
    half0_i = a; half1_i = b; key_i = k; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    half0_i = ~a; half1_i = b ^ 32'h5A5A_5A5A; key_i = ~k;
    cyc = 1;
    busy_ok = 1;
    while (!done_o && cyc < 100) begin
      if (!busy_o) busy_ok = 0;
      if (cyc == poke_at) start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check("R5 latency", 64'(cyc), 64'd32);
    check("R6 busy through block", {63'd0, busy_ok}, 64'd1);
    check("R6 busy low at done", {63'd0, busy_o}, 64'd0);
    check(poke_at > 0 ? "R7 start ignored" : "R1 R2 R3 R4 ciphertext",
          {half0_o, half1_o}, exp);
    @(negedge clk);
    check("R5 done single cycle", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9
    check("R9 reset busy", {63'd0, busy_o}, 64'd0);
    check("R9 reset done", {63'd0, done_o}, 64'd0);
    check("R9 reset outputs", {half0_o, half1_o}, 64'd0);
    rst_n = 1'b1;
    // R10 all zero
    run_block(32'd0, 32'd0, 128'd0, 0);
    check("R10 zero vector", {half0_o, half1_o}, ref_enc(0, 0, 0));
    // directed corners for R2 R3 key selection
    run_block(32'hFFFF_FFFF, 32'hFFFF_FFFF, {128{1'b1}}, 0);
    run_block(32'h0123_4567, 32'h89AB_CDEF,
              {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 0);
    // random blocks
    for (int n = 0; n < 12; n++)
      run_block($urandom, $urandom, {$urandom, $urandom, $urandom, $urandom}, 0);
    // R7 starts during a block
    run_block($urandom, $urandom, {$urandom, $urandom, $urandom, $urandom}, 1);
    run_block($urandom, $urandom, {$urandom, $urandom, $urandom, $urandom}, 16);
    run_block($urandom, $urandom, {$urandom, $urandom, $urandom, $urandom}, 31);
    // R8 hold
    held = {half0_o, half1_o};
    half0_i = $urandom; half1_i = $urandom; key_i = {4{$urandom}};
    repeat (6) @(negedge clk);
    check("R8 output hold", {half0_o, half1_o}, held);
    check("R8 no stray done", {63'd0, done_o}, 64'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule